// File: doc/BRIEF.md
# Disk Controller Command and Status Register

This block is the host-facing register front end of a head-per-track disk controller. A host issues programmed I/O accesses, each made of up to three pulse bits and a subcode, with an 18-bit accumulator value. The block turns each access into register operations. An access can clear flags, test for a skip, read back status or the disk address, load the memory address, load the word count, load the disk address, or load the function bits. The 18-bit status word holds four error flags, an error summary, done, interrupt enable, busy and a write/read direction bit. The error summary is rebuilt after every cycle, and done always wins over busy.

A small two-state sequencer (XF_IDLE, XF_RUN) tracks whether a transfer is in flight. A status load that leaves busy set while in XF_IDLE raises a one-cycle start and moves to XF_RUN (transition IDLE_TO_RUN). In XF_RUN, a status load that leaves busy clear raises a one-cycle cancel and returns to XF_IDLE (transition RUN_CANCEL). A done event or any error event from the transfer engine also returns to XF_IDLE (transition RUN_FINISH). The loaded disk address, memory address and word count go to the transfer engine. The engine reports done and error events back into the status word.

Top module: `csr_disk_ctl`

## Requirements
- R1: An access happens in a cycle with `io_strobe` high. `io_sub` codes 0, 1 and 2 select the three operation groups, and code 3 selects nothing. Status bit positions: 17 error summary, 16 parity, 15 illegal address, 14 timing, 13 not ready, 12 done, 11 interrupt enable, 10 busy, 9 write. Bits 8..0 always read zero.
- R2: A status load (pulse bit 2, subcode 2) builds the new word as follows. From the old value it keeps only interrupt enable, busy and write. It XORs in the accumulator with bits 8..0 masked off. Loading busy while busy is already set therefore clears busy.
- R3: After every cycle, the error summary bit is 1 exactly when at least one of parity, illegal address, timing or not ready is 1.
- R4: While done is 1, busy is 0.
- R5: `irq` is 1 one cycle after the status word holds interrupt enable together with error summary or done. It is 0 otherwise.
- R6: Pulse bit 0 with subcode 0 clears bits 17..12 of status and leaves bits 11..9 unchanged.
- R7: `skip` is 1 in the cycle of an access with pulse bit 0 and subcode 1 when error summary or done is 1. In all other cycles it is 0.
- R8: Pulse bit 0 with subcode 2 clears the whole status word.
- R9: `rd_data` is combinational within the access cycle. It shows the disk address for pulse bit 1 with subcode 0. It shows status for pulse bit 1 with subcode 1, including any pulse bit 0 clear done in the same access. Otherwise it is zero.
- R10: Pulse bit 2 with subcode 0 loads all 18 bits of the disk address. Pulse bit 2 with subcode 1 loads the low 16 bits as the word count. Pulse bit 1 with subcode 2 loads the low `MA_W` bits as the memory address. Each is visible on its output one cycle later.
- R11: `xfer_start` pulses for one cycle when a status load leaves busy set after R4 is applied and no transfer is running.
- R12: `xfer_cancel` pulses for one cycle when a status load leaves busy clear while a transfer is running. It never pulses when no transfer is running.
- R13: `ev_flags` (bit 3 parity, 2 illegal address, 1 timing, 0 not ready) and `ev_done` are ORed into status after the access. A done event or any error event ends a running transfer.
- R14: A synchronous reset clears status, disk address, memory address and word count, deasserts `irq` and returns to XF_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_strobe | input | 1 | Access valid this cycle |
| io_pulse | input | 3 | Pulse bits of the access |
| io_sub | input | 2 | Subcode selecting the operation group |
| io_acc | input | 18 | Accumulator value from the host |
| ev_flags | input | 4 | Error events from the transfer engine |
| ev_done | input | 1 | Done event from the transfer engine |
| rd_data | output | 18 | Read data of the access |
| skip | output | 1 | Skip indication of a flag test |
| xfer_start | output | 1 | Start a transfer |
| xfer_cancel | output | 1 | Cancel the running transfer |
| irq | output | 1 | Interrupt request |
| da_q | output | 18 | Disk address |
| ma_q | output | MA_W | Memory address |
| wc_q | output | WC_W | Word count |

## Verification
Seeded random accesses cover all pulse bit combinations, including multi-bit pulses. They also cover all four subcodes, full-range accumulator values and sparse engine events. This exercises the ordering of clear, read and load inside a single access, and shows that subcode 3 is inert. Directed accesses cover four cases. A repeated busy load toggles busy off through the XOR and gives a cancel rather than a second start. A done event clears busy and raises the interrupt. Clearing flags drops the interrupt while keeping the function bits. Wide loads are truncated to the word count and memory address widths.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int SW = 18;
    localparam int B_ERR = 17;
    localparam int B_DON = 12;
    localparam int B_IE  = 11;
    localparam int B_BSY = 10;
    localparam logic [SW-1:0] KEEP_MASK = 18'o007000;
    localparam logic [SW-1:0] ZERO_MASK = 18'o000777;
    localparam logic [SW-1:0] FLAG_MASK = 18'o360000;
    localparam logic [SW-1:0] CLR_MASK  = 18'o770000;

    typedef enum logic [1:0] {SUB_LO = 2'd0, SUB_MID = 2'd1, SUB_HI = 2'd2} sub_t;
    typedef enum logic {XF_IDLE = 1'b0, XF_RUN = 1'b1} xf_state_t;

    typedef struct packed {
        logic clr_flags;
        logic skip_test;
        logic clr_all;
        logic rd_da;
        logic rd_stat;
        logic ld_ma;
        logic ld_da;
        logic ld_wc;
        logic ld_stat;
    } pio_ops_t;

    function automatic logic [SW-1:0] stat_norm(input logic [SW-1:0] s);
        logic [SW-1:0] r;
        r = s & ~ZERO_MASK;
        r[B_ERR] = |(r & FLAG_MASK);
        if (r[B_DON]) r[B_BSY] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/csr_pio_decode.sv
module csr_pio_decode (
    input  logic                io_strobe,
    input  logic [2:0]          io_pulse,
    input  logic [1:0]          io_sub,
    output csr_pkg::pio_ops_t   ops
);
    localparam int NP = 3;
    localparam int NS = 3;
    logic [NP*NS-1:0] grid;

    for (genvar p = 0; p < NP; p++) begin : g_pulse
        for (genvar s = 0; s < NS; s++) begin : g_sub
            assign grid[p*NS+s] = io_strobe & io_pulse[p] & (io_sub == 2'(s));
        end
    end

    always_comb begin
        ops.clr_flags = grid[0];
        ops.skip_test = grid[1];
        ops.clr_all   = grid[2];
        ops.rd_da     = grid[3];
        ops.rd_stat   = grid[4];
        ops.ld_ma     = grid[5];
        ops.ld_da     = grid[6];
        ops.ld_wc     = grid[7];
        ops.ld_stat   = grid[8];
    end
endmodule

// File: rtl/csr_stat_core.sv
module csr_stat_core (
    input  logic                    clk,
    input  logic                    rst,
    input  csr_pkg::pio_ops_t       ops,
    input  logic [csr_pkg::SW-1:0]  acc,
    input  logic [3:0]              ev_flags,
    input  logic                    ev_done,
    output logic [csr_pkg::SW-1:0]  stat_q,
    output logic [csr_pkg::SW-1:0]  stat_view,
    output logic                    ld_busy,
    output logic                    irq
);
    import csr_pkg::*;

    logic [SW-1:0] s_acc;
    logic [SW-1:0] s_ld;
    logic [SW-1:0] s_ldn;
    logic [SW-1:0] s_nx;

    always_comb begin
        s_acc = stat_q;
        if (ops.clr_all)
            s_acc = '0;
        else if (ops.clr_flags)
            s_acc = stat_q & ~CLR_MASK;
        s_ld  = ops.ld_stat ? ((s_acc & KEEP_MASK) ^ (acc & ~ZERO_MASK)) : s_acc;
        s_ldn = stat_norm(s_ld);
        s_nx  = stat_norm(s_ld | {1'b0, ev_flags, ev_done, 12'b0});
    end

    assign stat_view = s_acc;
    assign ld_busy   = s_ldn[B_BSY];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            irq    <= 1'b0;
        end else begin
            stat_q <= s_nx;
            irq    <= s_nx[B_IE] & (s_nx[B_ERR] | s_nx[B_DON]);
        end
    end
endmodule

// File: rtl/csr_xfer_fsm.sv
module csr_xfer_fsm (
    input  logic clk,
    input  logic rst,
    input  logic ld_stat,
    input  logic ld_busy,
    input  logic ev_fin,
    output logic xfer_start,
    output logic xfer_cancel
);
    import csr_pkg::*;

    xf_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= XF_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (ld_stat && ld_busy) state_d = XF_RUN;
            XF_RUN:  if ((ld_stat && !ld_busy) || ev_fin) state_d = XF_IDLE;
            default: state_d = XF_IDLE;
        endcase
    end

    always_comb begin
        xfer_start  = 1'b0;
        xfer_cancel = 1'b0;
        unique case (state_q)
            XF_IDLE: xfer_start  = ld_stat & ld_busy;
            XF_RUN:  xfer_cancel = ld_stat & ~ld_busy;
            default: ;
        endcase
    end
endmodule

// File: rtl/csr_disk_ctl.sv
module csr_disk_ctl #(
    parameter int MA_W = 15,
    parameter int WC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            io_strobe,
    input  logic [2:0]      io_pulse,
    input  logic [1:0]      io_sub,
    input  logic [17:0]     io_acc,
    input  logic [3:0]      ev_flags,
    input  logic            ev_done,
    output logic [17:0]     rd_data,
    output logic            skip,
    output logic            xfer_start,
    output logic            xfer_cancel,
    output logic            irq,
    output logic [17:0]     da_q,
    output logic [MA_W-1:0] ma_q,
    output logic [WC_W-1:0] wc_q
);
    import csr_pkg::*;

    pio_ops_t       ops;
    logic [SW-1:0]  stat_q;
    logic [SW-1:0]  stat_view;
    logic           ld_busy;

    csr_pio_decode u_dec (
        .io_strobe (io_strobe),
        .io_pulse  (io_pulse),
        .io_sub    (io_sub),
        .ops       (ops)
    );

    csr_stat_core u_stat (
        .clk       (clk),
        .rst       (rst),
        .ops       (ops),
        .acc       (io_acc),
        .ev_flags  (ev_flags),
        .ev_done   (ev_done),
        .stat_q    (stat_q),
        .stat_view (stat_view),
        .ld_busy   (ld_busy),
        .irq       (irq)
    );

    csr_xfer_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ld_stat     (ops.ld_stat),
        .ld_busy     (ld_busy),
        .ev_fin      (ev_done | (|ev_flags)),
        .xfer_start  (xfer_start),
        .xfer_cancel (xfer_cancel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            da_q <= '0;
            ma_q <= '0;
            wc_q <= '0;
        end else begin
            if (ops.ld_da) da_q <= io_acc;
            if (ops.ld_ma) ma_q <= io_acc[MA_W-1:0];
            if (ops.ld_wc) wc_q <= io_acc[WC_W-1:0];
        end
    end

    always_comb begin
        if (ops.rd_da)        rd_data = da_q;
        else if (ops.rd_stat) rd_data = stat_view;
        else                  rd_data = '0;
    end

    assign skip = ops.skip_test & (stat_q[B_ERR] | stat_q[B_DON]);
endmodule

// File: rtl/csr_disk_ctl_chk.sv
module csr_disk_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        io_strobe,
    input logic [2:0]  io_pulse,
    input logic [1:0]  io_sub,
    input logic [3:0]  ev_flags,
    input logic        ev_done,
    input logic [17:0] rd_data,
    input logic [17:0] stat_q,
    input logic [17:0] da_q,
    input logic        xfer_start,
    input logic        xfer_cancel,
    input logic        irq
);
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && io_pulse[1] && io_sub == 2'd1) |-> rd_data[8:0] == 9'd0); // R1
    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        stat_q[17] == (|stat_q[16:13])); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        stat_q[12] |-> !stat_q[10]); // R4
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq == (stat_q[11] && (stat_q[17] || stat_q[12]))); // R5
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && io_pulse[0] && !io_pulse[2] && io_sub == 2'd2 && ev_flags == 4'd0 && !ev_done)
        |=> stat_q == 18'd0); // R8
    AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start); // R11
    AST_CANCEL_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        xfer_cancel |-> (io_strobe && io_pulse[2] && io_sub == 2'd2 && !xfer_start)); // R12
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (stat_q == 18'd0 && da_q == 18'd0 && !irq)); // R14
endmodule

bind csr_disk_ctl csr_disk_ctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .io_strobe   (io_strobe),
    .io_pulse    (io_pulse),
    .io_sub      (io_sub),
    .ev_flags    (ev_flags),
    .ev_done     (ev_done),
    .rd_data     (rd_data),
    .stat_q      (stat_q),
    .da_q        (da_q),
    .xfer_start  (xfer_start),
    .xfer_cancel (xfer_cancel),
    .irq         (irq)
);

// File: tb/sim_csr_disk_ctl.sv
module sim_csr_disk_ctl;
    localparam int MA_W = 15;
    localparam int WC_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic io_strobe = 1'b0;
    logic [2:0] io_pulse = '0;
    logic [1:0] io_sub = '0;
    logic [17:0] io_acc = '0;
    logic [3:0] ev_flags = '0;
    logic ev_done = 1'b0;
    logic [17:0] rd_data;
    logic skip, xfer_start, xfer_cancel, irq;
    logic [17:0] da_q;
    logic [MA_W-1:0] ma_q;
    logic [WC_W-1:0] wc_q;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [17:0] m_stat = '0;
    logic [17:0] m_da = '0;
    logic [MA_W-1:0] m_ma = '0;
    logic [WC_W-1:0] m_wc = '0;
    logic m_run = 1'b0;
    logic m_irq = 1'b0;

    always #2 clk = ~clk;

    csr_disk_ctl #(.MA_W(MA_W), .WC_W(WC_W)) u0 (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_pulse(io_pulse),
        .io_sub(io_sub), .io_acc(io_acc), .ev_flags(ev_flags), .ev_done(ev_done),
        .rd_data(rd_data), .skip(skip), .xfer_start(xfer_start),
        .xfer_cancel(xfer_cancel), .irq(irq), .da_q(da_q), .ma_q(ma_q), .wc_q(wc_q)
    );

    function automatic logic [17:0] f_norm(input logic [17:0] s);
        logic [17:0] r;
        r = s & 18'o777000;
        r[17] = (r[16] | r[15] | r[14] | r[13]);
        if (r[12]) r[10] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic stb, input logic [2:0] p, input logic [1:0] s,
                          input logic [17:0] a, input logic [3:0] ef, input logic ed);
        logic [17:0] s1, s2, e_rd, nxt;
        logic e_skip, busy_l, e_start, e_cancel, g0, g1, g2;
        @(negedge clk);
        io_strobe = stb; io_pulse = p; io_sub = s; io_acc = a; ev_flags = ef; ev_done = ed;
        #1;
        g0 = stb & (s == 2'd0); g1 = stb & (s == 2'd1); g2 = stb & (s == 2'd2);
        s1 = m_stat;
        if (p[0] & g2) s1 = '0;
        else if (p[0] & g0) s1 = m_stat & 18'o007777;
        e_rd = (p[1] & g0) ? m_da : ((p[1] & g1) ? s1 : 18'd0);
        e_skip = p[0] & g1 & (m_stat[17] | m_stat[12]);
        s2 = (p[2] & g2) ? ((s1 & 18'o007000) ^ (a & 18'o777000)) : s1;
        busy_l = f_norm(s2) ;
        busy_l = f_norm(s2)[10] ;
        e_start = p[2] & g2 & busy_l & ~m_run;
        e_cancel = p[2] & g2 & ~busy_l & m_run;
        chk("R9 rd_data (status path R1 R2 R3 R4 R6 R8 R13)", rd_data, e_rd);
        chk("R7 skip", skip, e_skip);
        chk("R11 xfer_start", xfer_start, e_start);
        chk("R12 xfer_cancel", xfer_cancel, e_cancel);
        nxt = f_norm(s2 | {1'b0, ef, ed, 12'b0});
        if (m_run) m_run = ~(e_cancel | ed | (|ef));
        else       m_run = e_start;
        m_stat = nxt;
        m_irq = nxt[11] & (nxt[17] | nxt[12]);
        if (p[2] & g0) m_da = a;
        if (p[2] & g1) m_wc = a[WC_W-1:0];
        if (p[1] & g2) m_ma = a[MA_W-1:0];
        @(posedge clk);
        #1;
        chk("R5 irq", irq, m_irq);
        chk("R10 da_q", da_q, m_da);
        chk("R10 ma_q", ma_q, m_ma);
        chk("R10 wc_q", wc_q, m_wc);
    endtask

    task automatic rd_stat_chk(input string req, input logic [17:0] exp);
        @(negedge clk);
        io_strobe = 1; io_pulse = 3'b010; io_sub = 2'd1; ev_flags = '0; ev_done = 0;
        #1;
        chk(req, rd_data, exp);
        access(1'b0, 3'd0, 2'd0, 18'd0, 4'd0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R14 reset irq", irq, 0);
        chk("R14 reset da", da_q, 0);
        chk("R14 reset wc", wc_q, 0);
        @(negedge clk); rst = 0;
        rd_stat_chk("R14 reset status", 18'd0);
        // R1 R2: low nine bits masked, interrupt enable loaded
        access(1, 3'b100, 2'd2, 18'o004777, 4'd0, 0);
        rd_stat_chk("R1 R2 load masks low bits", 18'o004000);
        // R11 start, then R2 XOR toggles busy off giving R12 cancel
        access(1, 3'b100, 2'd2, 18'o002000, 4'd0, 0);
        access(1, 3'b100, 2'd2, 18'o002000, 4'd0, 0);
        rd_stat_chk("R2 busy toggled off", 18'o004000);
        access(1, 3'b100, 2'd2, 18'o002000, 4'd0, 0);
        // R13 R4 R5: done ends transfer, clears busy, raises irq
        access(1, 3'b000, 2'd0, 18'd0, 4'd0, 1);
        rd_stat_chk("R4 R13 done clears busy", 18'o014000);
        chk("R5 irq on done", irq, 1);
        access(1, 3'b001, 2'd1, 18'd0, 4'd0, 0);      // R7 skip
        access(1, 3'b001, 2'd0, 18'd0, 4'd0, 0);      // R6 clear flags
        rd_stat_chk("R6 flags cleared keep enable", 18'o004000);
        access(1, 3'b000, 2'd0, 18'd0, 4'b1000, 0);   // R3 parity event
        rd_stat_chk("R3 error summary", 18'o604000);
        access(1, 3'b001, 2'd2, 18'd0, 4'd0, 0);      // R8 clear all
        rd_stat_chk("R8 clear all", 18'd0);
        access(1, 3'b100, 2'd1, 18'o777777, 4'd0, 0); // R10 wc truncation
        access(1, 3'b010, 2'd2, 18'o777777, 4'd0, 0); // R10 ma truncation
        access(1, 3'b100, 2'd0, 18'o123456, 4'd0, 0); // R10 da load
        access(1, 3'b010, 2'd0, 18'd0, 4'd0, 0);      // R9 da read
        access(1, 3'b111, 2'd3, 18'o777777, 4'd0, 0); // R1 subcode 3 inert
        rd_stat_chk("R1 subcode 3 inert", 18'd0);
        // R4 load with done and busy together: no start
        access(1, 3'b100, 2'd2, 18'o016000, 4'd0, 0);
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ef;
            ef = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'd0;
            access(($urandom_range(0, 9) != 0), 3'($urandom), 2'($urandom),
                   18'($urandom), ef, ($urandom_range(0, 11) == 0));
        end
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule